// File: doc/BRIEF.md
# Parallel Display Bus Write Sequencer

This block sends single bytes to a display controller over an 8-bit parallel bus of the 8080 kind, with separate active-low write and read strobes. A client hands over one byte at a time on a valid/ready handshake. Each request carries a flag that marks the byte as display data or as a command. The block then runs a complete write cycle on the bus: it selects the device, sets the data/command line and drives the byte, pulses the write strobe low, holds everything for a while after the strobe, and then releases the bus.

Each phase of the cycle lasts a whole number of system clock cycles. The counts come from parameters: the clock period and the minimum times in nanoseconds, converted by ceiling division, with each count at least 1. Write strobe low time, data setup, select hold, data hold, strobe high time and the full strobe-to-strobe period are all covered. The block only writes. The read strobe is held inactive at all times. After reset the bus is idle: select, write strobe and read strobe high, and the data bus not driven.

Top module: `par8_wr_master`

## Requirements
- R1: The data/command line `bus_dc` equals the request's `in_is_data` flag throughout the write: 1 (high) for a display-data byte, 0 (low) for a command byte.
- R2: A request is accepted at a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when idle. It is 0 from the accepting edge for exactly AS+LOW+HOLD+GAP cycles.
- R3: The write strobe `bus_wr_n` stays low for exactly LOW = max(ceil(60 ns/T), ceil(40 ns/T)) cycles, where T is the clock period.
- R4: `bus_cs_n` falls at the accepting edge, and `bus_wr_n` falls AS = ceil(10 ns/T) cycles later. The write strobe is only ever low while `bus_cs_n` is low.
- R5: After `bus_wr_n` rises, `bus_cs_n` stays low for HOLD = max(ceil(20 ns/T), ceil(7 ns/T)) more cycles.
- R6: Successive falling edges of `bus_wr_n` are at least CYC = ceil(300 ns/T) cycles apart. The strobe stays high for at least ceil(60 ns/T) cycles between pulses. GAP = max(1, CYC-LOW-HOLD-AS, ceil(60 ns/T)-HOLD-AS) select-released cycles follow each write.
- R7: `bus_dq_oe` is 1 exactly while `bus_cs_n` is 0.
- R8: The read strobe `bus_rd_n` is 1 at all times.
- R9: While `rst` is 1 at a clock edge, the block goes idle, even if `in_valid` is 1: `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1, `bus_dq_oe` is 0 and `in_ready` is 1.
- R10: `bus_dq_o` and `bus_dc` do not change while `bus_cs_n` stays low.
- R11: Throughout the write, `bus_dq_o` carries the accepted `in_byte` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, able to accept a request |
| in_byte | input | 8 | Byte to write |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| bus_cs_n | output | 1 | Device select, active low |
| bus_dc | output | 1 | Data/command line |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, held high |
| bus_dq_o | output | 8 | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |

## Verification
The properties assume that the client behaves well: a request stays presented with a steady byte and flag until the block accepts it, and reset is applied from time zero. The bench meets this. It changes `in_valid`, `in_byte` and `in_is_data` only on falling clock edges, and only while `in_ready` is 1 or just after the accepting edge. It sweeps every byte value with both flag settings, some requests back to back and some after idle gaps, so that the strobe-to-strobe period is checked both at its minimum and with slack.

// File: rtl/par8_wr_master.sv
module par8_wr_master #(
  parameter int CLK_NS    = 4,
  parameter int T_CYC_NS  = 300,
  parameter int T_AS_NS   = 10,
  parameter int T_DSW_NS  = 40,
  parameter int T_DHW_NS  = 7,
  parameter int T_PWL_NS  = 60,
  parameter int T_PWH_NS  = 60,
  parameter int T_CSF_NS  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  output logic       bus_cs_n,
  output logic       bus_dc,
  output logic       bus_wr_n,
  output logic       bus_rd_n,
  output logic [7:0] bus_dq_o,
  output logic       bus_dq_oe
);
  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_AS   = ns2cyc(T_AS_NS);
  localparam int N_LOW  = imax(ns2cyc(T_PWL_NS), ns2cyc(T_DSW_NS));
  localparam int N_HOLD = imax(ns2cyc(T_CSF_NS), ns2cyc(T_DHW_NS));
  localparam int N_CYC  = ns2cyc(T_CYC_NS);
  localparam int N_PWH  = ns2cyc(T_PWH_NS);
  localparam int N_GAP  = imax(1, imax(N_CYC - N_LOW - N_HOLD - N_AS, N_PWH - N_HOLD - N_AS));
  localparam int N_MAX  = imax(imax(N_AS, N_LOW), imax(N_HOLD, N_GAP));
  localparam int CW     = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {IDLE, SETUP, LOW, HOLD, GAP} phase_t;

  phase_t        st, nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [7:0]    dat_q;
  logic          dc_q, cs_q, wr_q, oe_q;
  logic          last;

  assign last     = (cnt == '0);
  assign in_ready = (st == IDLE);

  always_comb begin
    nxt     = st;
    cnt_nxt = cnt - 1'b1;
    case (st)
      IDLE: begin
        cnt_nxt = '0;
        if (in_valid) begin
          nxt     = SETUP;
          cnt_nxt = CW'(N_AS - 1);
        end
      end
      SETUP: if (last) begin nxt = LOW;  cnt_nxt = CW'(N_LOW - 1);  end
      LOW:   if (last) begin nxt = HOLD; cnt_nxt = CW'(N_HOLD - 1); end
      HOLD:  if (last) begin nxt = GAP;  cnt_nxt = CW'(N_GAP - 1);  end
      GAP:   if (last) begin nxt = IDLE; cnt_nxt = '0;              end
      default: begin nxt = IDLE; cnt_nxt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= IDLE;
      cnt   <= '0;
      cs_q  <= 1'b1;
      wr_q  <= 1'b1;
      oe_q  <= 1'b0;
      dat_q <= 8'h00;
      dc_q  <= 1'b0;
    end else begin
      st    <= nxt;
      cnt   <= cnt_nxt;
      cs_q  <= !(nxt == SETUP || nxt == LOW || nxt == HOLD);
      oe_q  <=  (nxt == SETUP || nxt == LOW || nxt == HOLD);
      wr_q  <= (nxt != LOW);
      if (in_valid && in_ready) begin
        dat_q <= in_byte;
        dc_q  <= in_is_data;
      end
    end
  end

  assign bus_cs_n  = cs_q;
  assign bus_wr_n  = wr_q;
  assign bus_rd_n  = 1'b1;
  assign bus_dc    = dc_q;
  assign bus_dq_o  = dat_q;
  assign bus_dq_oe = oe_q;
endmodule

module par8_wr_checker #(
  parameter int N_AS   = 1,
  parameter int N_LOW  = 1,
  parameter int N_HOLD = 1,
  parameter int N_CYC  = 1,
  parameter int N_PWH  = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       bus_cs_n,
  input logic       bus_dc,
  input logic       bus_wr_n,
  input logic       bus_rd_n,
  input logic [7:0] bus_dq_o,
  input logic       bus_dq_oe
);
  localparam logic [31:0] SAT = 32'hFFFF_FFFF;
  logic [31:0] lo_cnt, csw_cnt, hi_cnt, fall_gap;
  logic        wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt   <= '0;
      csw_cnt  <= '0;
      hi_cnt   <= SAT;
      fall_gap <= SAT;
      wr_prev  <= 1'b1;
    end else begin
      wr_prev  <= bus_wr_n;
      lo_cnt   <= !bus_wr_n ? lo_cnt + 1 : '0;
      csw_cnt  <= (!bus_cs_n && bus_wr_n) ? csw_cnt + 1 : '0;
      if (!bus_wr_n) hi_cnt <= '0;
      else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1;
      if (!bus_wr_n && wr_prev) fall_gap <= 32'd1;
      else if (fall_gap != SAT) fall_gap <= fall_gap + 1;
    end
  end

  p_rd_high_r8: assert property (@(posedge clk) disable iff (rst) bus_rd_n);
  p_oe_cs_r7: assert property (@(posedge clk) disable iff (rst) bus_dq_oe == !bus_cs_n);
  p_wr_in_cs_r4: assert property (@(posedge clk) disable iff (rst) !bus_wr_n |-> !bus_cs_n);
  p_busy_r2: assert property (@(posedge clk) disable iff (rst) !bus_cs_n |-> !in_ready);
  p_steady_r10: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !$past(bus_cs_n)) |-> ($stable(bus_dc) && $stable(bus_dq_o)));
  p_low_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> lo_cnt >= 32'(N_LOW));
  p_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr_n) |-> csw_cnt >= 32'(N_AS));
  p_cs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> csw_cnt >= 32'(N_HOLD));
  p_period_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr_n) |-> fall_gap >= 32'(N_CYC));
  p_high_width_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr_n) |-> hi_cnt >= 32'(N_PWH));
endmodule

bind par8_wr_master par8_wr_checker #(
  .N_AS(N_AS), .N_LOW(N_LOW), .N_HOLD(N_HOLD), .N_CYC(N_CYC), .N_PWH(N_PWH)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
  .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe)
);

// File: tb/tb_par8_wr_master.sv
module tb_par8_wr_master;
  localparam int CLK_NS = 4;

  function automatic int c2(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_AS   = c2(10);
  localparam int E_LOW  = mx(c2(60), c2(40));
  localparam int E_HOLD = mx(c2(20), c2(7));
  localparam int E_CYC  = c2(300);
  localparam int E_PWH  = c2(60);
  localparam int E_GAP  = mx(1, mx(E_CYC - E_LOW - E_HOLD - E_AS, E_PWH - E_HOLD - E_AS));
  localparam int E_BUSY = E_AS + E_LOW + E_HOLD + E_GAP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_is_data = 1'b0;
  logic       in_ready, bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_dq_oe;
  logic [7:0] bus_dq_o;

  par8_wr_master #(.CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .bus_cs_n(bus_cs_n),
    .bus_dc(bus_dc), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe)
  );

  always #2ns clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_b = 8'h00;
  logic       exp_d = 1'b0;
  int e_dat = 0, e_dc = 0, e_oe = 0, e_rdy = 0, g_oe = 0, g_rd = 0;
  int t_csf = 0, t_csr = 0, t_wrf = 0, t_wrr = 0;
  logic pcs = 1'b1, pwr = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_cs_n) begin
        if (bus_dq_o !== exp_b) e_dat++;
        if (bus_dc !== exp_d) e_dc++;
        if (bus_dq_oe !== 1'b1) e_oe++;
        if (in_ready !== 1'b0) e_rdy++;
      end else if (bus_dq_oe !== 1'b0) g_oe++;
      if (bus_rd_n !== 1'b1) g_rd++;
      if (pcs && !bus_cs_n) t_csf = cyc;
      if (!pcs && bus_cs_n) t_csr = cyc;
      if (pwr && !bus_wr_n) t_wrf = cyc;
      if (!pwr && bus_wr_n) t_wrr = cyc;
      pcs = bus_cs_n;
      pwr = bus_wr_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int prev_wrf = -1, prev_wrr = -1;

  task automatic send(input logic [7:0] b, input logic d, input int gap);
    int acc;
    repeat (gap) @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_data = d;
    while (!in_ready) @(negedge clk);
    exp_b = b; exp_d = d;
    e_dat = 0; e_dc = 0; e_oe = 0; e_rdy = 0;
    acc = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    chk(cyc - acc == E_BUSY, "R2 busy length", cyc - acc, E_BUSY);
    chk(e_rdy == 0, "R2 ready low during select", e_rdy, 0);
    chk(t_csf == acc, "R4 select fall", t_csf - acc, 0);
    chk(t_wrf - acc == E_AS, "R4 setup before strobe", t_wrf - acc, E_AS);
    chk(t_wrr - t_wrf == E_LOW, "R3 strobe low width", t_wrr - t_wrf, E_LOW);
    chk(t_csr - t_wrr == E_HOLD, "R5 select hold", t_csr - t_wrr, E_HOLD);
    chk(e_dc == 0, "R1 dc level", e_dc, 0);
    chk(e_dat == 0, "R11 byte on bus", e_dat, 0);
    chk(e_oe == 0, "R7 enable while selected", e_oe, 0);
    if (prev_wrf >= 0) begin
      chk(t_wrf - prev_wrf >= E_CYC, "R6 strobe period", t_wrf - prev_wrf, E_CYC);
      chk(t_wrf - prev_wrr >= E_PWH, "R6 strobe high width", t_wrf - prev_wrr, E_PWH);
    end
    prev_wrf = t_wrf;
    prev_wrr = t_wrr;
  endtask

  initial begin
    #800us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    in_byte = 8'hA5;
    repeat (4) @(negedge clk);
    chk(bus_cs_n === 1'b1, "R9 select idle", int'(bus_cs_n), 1);
    chk(bus_wr_n === 1'b1, "R9 strobe idle", int'(bus_wr_n), 1);
    chk(bus_rd_n === 1'b1, "R9 read idle", int'(bus_rd_n), 1);
    chk(bus_dq_oe === 1'b0, "R9 enable off", int'(bus_dq_oe), 0);
    chk(in_ready === 1'b1, "R9 ready", int'(in_ready), 1);
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n === 1'b1, "R9 stays idle", int'(bus_cs_n), 1);
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 256; b++) begin
        send(8'(b), d[0], (b % 4 == 0) ? 3 : 0);
      end
    end
    repeat (4) @(negedge clk);
    chk(g_rd == 0, "R8 read strobe high", g_rd, 0);
    chk(g_oe == 0, "R7 enable off while deselected", g_oe, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule